// File: doc/BRIEF.md
# Converter Bus Control and Status Sequencer

This block sits between a microprocessor bus and a successive-approximation conversion core. It decodes three control lines into convert-start and data-read operations: an active-low select, an active-low enable and a read/write line. It filters start requests by a minimum low time counted in clock cycles. It runs a busy flag for the whole of each conversion and latches two input-mode bits from the bus when a conversion starts. It also gates a registered output-enable for the result data.

It talks to the core through a one-cycle start pulse and a done strobe that carries the result. Start requests that arrive while a conversion runs are ignored, and a running conversion cannot be stopped. When all three control lines stay low, conversions repeat back to back. If read/write then rises while the busy flag is high, the running conversion finishes and its result becomes readable.

Top module: `adc_bus_ctrl`

## Requirements
- R1: The lines decode as follows. With cs_ni=0 and ce_ni=0, rw_i=0 is a convert request and rw_i=1 is a read request. With cs_ni=1 or ce_ni=1, no operation is decoded, so no start occurs and bus_oe_o stays 0.
- R2: cs_ni and ce_ni are interchangeable qualifiers. The order in which the three lines fall does not matter: the low-time count starts in the first cycle in which all three are low. A read ends when either qualifier goes high.
- R3: A start needs the convert request present on MIN_W consecutive rising edges. status_o rises after the MIN_W-th such edge, and conv_start_o pulses high for exactly that one cycle. A shorter request produces no start.
- R4: While status_o is high, convert requests are ignored. status_o stays high until the core reports done, so a running conversion can be neither aborted nor restarted.
- R5: status_o clears at the clock edge that samples conv_done_i high. The result register captures conv_result_i at that same edge.
- R6: bus_oe_o is registered. It is 1 in the cycle after a read request is decoded while status_o is low, and it returns to 0 one cycle after the request ends. bus_o shows the result register when bus_oe_o is 1 and shows all zeros otherwise.
- R7: bus_oe_o is never 1 while status_o is 1.
- R8: While a convert request is held, a new conversion starts on the edge after status_o falls, so status_o is low for exactly one cycle between conversions.
- R9: If rw_i rises while status_o is high, the running conversion completes and no further start occurs. bus_oe_o then rises one cycle after status_o falls, and bus_o carries the new result.
- R10: At a start, bus_i[0] is latched to bipolar_o and bus_i[1] is latched to twos_o. Both are held until the next start, whatever the bus does in between.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| cs_ni | input | 1 | Active-low select qualifier |
| ce_ni | input | 1 | Active-low enable qualifier |
| rw_i | input | 1 | 1 = read, 0 = convert |
| bus_i | input | DATA_W | Bus data into the block; the two low bits carry the mode |
| bus_o | output | DATA_W | Result data, zero when not enabled |
| bus_oe_o | output | 1 | Bus drive enable for bus_o |
| status_o | output | 1 | High while a conversion runs |
| conv_start_o | output | 1 | One-cycle start pulse to the core |
| conv_done_i | input | 1 | Core done strobe |
| conv_result_i | input | DATA_W | Core result, valid with conv_done_i |
| bipolar_o | output | 1 | Latched bipolar input mode |
| twos_o | output | 1 | Latched two's-complement output mode |

## Verification
The bench builds the block with MIN_W=3 and DATA_W=8 and connects it to a core model whose conversions take eight cycles. A three-cycle filter lets the sweep try every request width from one to six, so both sides of the threshold are covered, as are requests that outlast the start and fall inside the lockout. The eight-cycle conversion leaves room for a full-width request to fall inside a running conversion. It also makes a continuous run produce several back-to-back conversions in a short window. All four mode-bit combinations are tried, and the three line orderings are each tried once.

// File: rtl/adc_bus_pkg.sv
package adc_bus_pkg;
  typedef enum logic [1:0] {
    OP_NONE    = 2'd0,
    OP_CONVERT = 2'd1,
    OP_READ    = 2'd2
  } bus_op_e;

  typedef struct packed {
    logic twos;
    logic bipolar;
  } conv_mode_t;

  localparam int MODE_W = $bits(conv_mode_t);
endpackage

// File: rtl/adc_bus_decode.sv
module adc_bus_decode
  import adc_bus_pkg::*;
(
  input  logic    cs_ni,
  input  logic    ce_ni,
  input  logic    rw_i,
  output bus_op_e op_o
);
  always_comb begin
    op_o = OP_NONE;
    if (!cs_ni && !ce_ni) op_o = rw_i ? OP_READ : OP_CONVERT;
  end
endmodule

// File: rtl/adc_start_qual.sv
module adc_start_qual #(
  parameter int MIN_W = 30
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic wr_req_i,
  input  logic busy_i,
  output logic fire_o
);
  localparam int CNT_W = (MIN_W < 2) ? 1 : $clog2(MIN_W);
  localparam logic [CNT_W-1:0] LAST = CNT_W'(MIN_W - 1);

  logic [CNT_W-1:0] cnt_q;

  // saturates at LAST so a held request keeps re-firing once busy drops
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              cnt_q <= '0;
    else if (!wr_req_i)       cnt_q <= '0;
    else if (cnt_q != LAST)   cnt_q <= cnt_q + 1'b1;
  end

  assign fire_o = wr_req_i && (cnt_q == LAST) && !busy_i;

  generate
    if (MIN_W > 1) begin : g_held_chk
      AST_FIRE_AFTER_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        fire_o |-> $past(wr_req_i)); // R3
    end
  endgenerate
endmodule

// File: rtl/adc_conv_track.sv
module adc_conv_track
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fire_i,
  input  conv_mode_t        mode_i,
  input  logic              done_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              status_o,
  output logic              start_o,
  output conv_mode_t        mode_o,
  output logic [DATA_W-1:0] result_o
);
  logic              status_q, start_q;
  conv_mode_t        mode_q;
  logic [DATA_W-1:0] result_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      status_q <= 1'b0;
      start_q  <= 1'b0;
      mode_q   <= '0;
      result_q <= '0;
    end else begin
      start_q <= 1'b0;
      if (!status_q && fire_i) begin
        status_q <= 1'b1;
        start_q  <= 1'b1;
        mode_q   <= mode_i;
      end else if (status_q && done_i) begin
        status_q <= 1'b0;
        result_q <= result_i;
      end
    end
  end

  assign status_o = status_q;
  assign start_o  = start_q;
  assign mode_o   = mode_q;
  assign result_o = result_q;

  AST_HOLD_UNTIL_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && !done_i) |=> status_q); // R4
  AST_START_WITH_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |-> status_q); // R3
  AST_START_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_q |=> !start_q); // R3
  AST_FALL_ON_DONE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(status_q) |-> $past(done_i)); // R5
  AST_MODE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_q && $past(status_q)) |-> $stable(mode_q)); // R10
endmodule

// File: rtl/adc_read_port.sv
module adc_read_port #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rd_req_i,
  input  logic              status_i,
  input  logic [DATA_W-1:0] result_i,
  output logic              oe_o,
  output logic [DATA_W-1:0] data_o
);
  logic oe_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) oe_q <= 1'b0;
    else         oe_q <= rd_req_i && !status_i;
  end

  assign oe_o   = oe_q;
  assign data_o = oe_q ? result_i : '0;

  AST_NO_OE_BUSY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> !status_i); // R7
  AST_OE_NEEDS_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    oe_q |-> $past(rd_req_i)); // R6
endmodule

// File: rtl/adc_bus_ctrl.sv
module adc_bus_ctrl
  import adc_bus_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int MIN_W  = 30
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cs_ni,
  input  logic              ce_ni,
  input  logic              rw_i,
  input  logic [DATA_W-1:0] bus_i,
  output logic [DATA_W-1:0] bus_o,
  output logic              bus_oe_o,
  output logic              status_o,
  output logic              conv_start_o,
  input  logic              conv_done_i,
  input  logic [DATA_W-1:0] conv_result_i,
  output logic              bipolar_o,
  output logic              twos_o
);
  bus_op_e           op;
  logic              fire, status;
  conv_mode_t        mode_lat;
  logic [DATA_W-1:0] result;

  adc_bus_decode i_decode (
    .cs_ni (cs_ni),
    .ce_ni (ce_ni),
    .rw_i  (rw_i),
    .op_o  (op)
  );

  adc_start_qual #(.MIN_W(MIN_W)) i_qual (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .wr_req_i (op == OP_CONVERT),
    .busy_i   (status),
    .fire_o   (fire)
  );

  adc_conv_track #(.DATA_W(DATA_W)) i_track (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .fire_i   (fire),
    .mode_i   (conv_mode_t'(bus_i[MODE_W-1:0])),
    .done_i   (conv_done_i),
    .result_i (conv_result_i),
    .status_o (status),
    .start_o  (conv_start_o),
    .mode_o   (mode_lat),
    .result_o (result)
  );

  adc_read_port #(.DATA_W(DATA_W)) i_read (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_req_i (op == OP_READ),
    .status_i (status),
    .result_i (result),
    .oe_o     (bus_oe_o),
    .data_o   (bus_o)
  );

  assign status_o  = status;
  assign bipolar_o = mode_lat.bipolar;
  assign twos_o    = mode_lat.twos;

  AST_NO_START_UNSELECTED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || ce_ni) |=> !conv_start_o); // R1
endmodule

// File: tb/test_adc_bus_ctrl.sv
module test_adc_bus_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int DW    = 8;
  localparam int MIN_W = 3;
  localparam int CONV  = 8;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n, ce_n, rw;
  logic [DW-1:0] bus_in, bus_out, core_res, exp_res;
  logic oe, status, start, done, bip, twos;
  int tcnt = 0;
  int starts = 0;
  int errors = 0, checks = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  adc_bus_ctrl #(.DATA_W(DW), .MIN_W(MIN_W)) i_adc_bus_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ce_ni(ce_n), .rw_i(rw),
    .bus_i(bus_in), .bus_o(bus_out), .bus_oe_o(oe), .status_o(status),
    .conv_start_o(start), .conv_done_i(done), .conv_result_i(core_res),
    .bipolar_o(bip), .twos_o(twos)
  );

  // core model: fixed latency, result sequence advances at each done
  assign done = (tcnt == 1);
  always @(posedge clk) begin
    if (!rst_n) begin
      tcnt <= 0; core_res <= 8'h5A; exp_res <= 8'h00;
    end else begin
      if (start) begin tcnt <= CONV; starts <= starts + 1; end
      else if (tcnt > 0) tcnt <= tcnt - 1;
      if (done) begin exp_res <= core_res; core_res <= core_res * 8'd5 + 8'd17; end
    end
  end

  task automatic tick(); @(posedge clk); #2; endtask

  task automatic check_eq(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic idle(); cs_n = 1'b1; ce_n = 1'b1; rw = 1'b1; endtask
  task automatic conv_req(); cs_n = 1'b0; ce_n = 1'b0; rw = 1'b0; endtask
  task automatic read_req(); cs_n = 1'b0; ce_n = 1'b0; rw = 1'b1; endtask

  // runs until status falls; checks R5 timing on every edge
  task automatic finish_conv();
    for (int i = 0; i < 100 && status; i++) begin
      logic d;
      d = done;
      tick();
      check_eq("R5", "status vs done", status, d ? 0 : 1);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    errors++; checks++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    int s0;
    idle(); bus_in = '0;
    repeat (3) tick();
    check_eq("R1", "reset status", status, 0);
    check_eq("R6", "reset oe", oe, 0);
    check_eq("R6", "reset bus_o", bus_out, 0);
    check_eq("R3", "reset start", start, 0);
    rst_n = 1'b1;
    repeat (2) tick();

    // R3: request width sweep around MIN_W
    for (int w = 1; w <= 6; w++) begin
      s0 = starts;
      conv_req();
      for (int k = 1; k <= w; k++) begin
        tick();
        check_eq("R3", $sformatf("status w=%0d k=%0d", w, k), status, (k >= MIN_W) ? 1 : 0);
        if (k == MIN_W) check_eq("R3", "start pulse", start, 1);
        if (k == MIN_W + 1) check_eq("R3", "start single", start, 0);
      end
      idle(); tick(); finish_conv(); tick();
      check_eq("R3", $sformatf("starts w=%0d", w), starts - s0, (w >= MIN_W) ? 1 : 0);
    end

    // R1/R2: one qualifier high blocks everything
    for (int q = 0; q < 2; q++) begin
      s0 = starts;
      cs_n = (q == 0); ce_n = (q == 1); rw = 1'b0;
      repeat (6) tick();
      check_eq("R1", $sformatf("no start q=%0d", q), starts - s0 + status, 0);
      rw = 1'b1;
      repeat (2) tick();
      check_eq("R1", $sformatf("no read oe q=%0d", q), oe, 0);
      idle(); tick();
    end

    // R2: line ordering
    for (int ord = 0; ord < 3; ord++) begin
      idle(); tick();
      case (ord)
        0: begin rw = 0; tick(); cs_n = 0; tick(); end
        1: begin ce_n = 0; tick(); rw = 0; tick(); end
        default: begin cs_n = 0; tick(); ce_n = 0; tick(); end
      endcase
      check_eq("R2", $sformatf("partial ord=%0d", ord), status, 0);
      conv_req();
      repeat (MIN_W - 1) tick();
      check_eq("R2", $sformatf("before width ord=%0d", ord), status, 0);
      tick();
      check_eq("R2", $sformatf("after width ord=%0d", ord), status, 1);
      idle(); tick(); finish_conv();
    end

    // R6/R2: read ended by either qualifier
    for (int q = 0; q < 2; q++) begin
      idle(); tick();
      read_req();
      check_eq("R6", "oe same cycle", oe, 0);
      tick();
      check_eq("R6", "oe after read", oe, 1);
      check_eq("R6", "read data", bus_out, exp_res);
      if (q == 0) cs_n = 1'b1; else ce_n = 1'b1;
      check_eq("R6", "oe before edge", oe, 1);
      tick();
      check_eq("R2", $sformatf("oe off q=%0d", q), oe, 0);
      check_eq("R6", "bus zero", bus_out, 0);
    end

    // R4: request during conversion ignored
    idle(); tick();
    s0 = starts;
    conv_req(); repeat (MIN_W) tick();
    idle(); tick();
    conv_req();
    for (int k = 0; k <= MIN_W; k++) begin
      tick();
      check_eq("R4", "status held", status, 1);
    end
    idle(); tick(); finish_conv(); repeat (3) tick();
    check_eq("R4", "single start", starts - s0, 1);
    check_eq("R4", "stays idle", status, 0);

    // R7: read during conversion
    conv_req(); repeat (MIN_W) tick();
    read_req();
    for (int i = 0; i < 40 && status; i++) begin
      tick();
      if (status) check_eq("R7", "oe while busy", oe, 0);
    end
    check_eq("R6", "oe at fall", oe, 0);
    tick();
    check_eq("R6", "oe after fall", oe, 1);
    check_eq("R6", "data after fall", bus_out, exp_res);
    idle(); tick();

    // R8: continuous conversion
    s0 = starts;
    conv_req();
    repeat (MIN_W) tick();
    for (int i = 0; i < 50; i++) begin
      logic ps;
      ps = status;
      tick();
      if (ps && !status) begin
        tick();
        check_eq("R8", "restart after one cycle", status, 1);
      end
      check_eq("R8", "oe in continuous", oe, 0);
    end
    check_eq("R8", "several conversions", (starts - s0 >= 4) ? 1 : 0, 1);

    // R9: rw rises during conversion -> final one, then readable
    for (int i = 0; i < 20 && !status; i++) tick();
    rw = 1'b1;
    s0 = starts;
    finish_conv();
    check_eq("R9", "oe at fall", oe, 0);
    tick();
    check_eq("R9", "oe after final", oe, 1);
    check_eq("R9", "final data", bus_out, exp_res);
    repeat (4) tick();
    check_eq("R9", "no further start", starts - s0, 0);
    idle(); tick();

    // R10: mode latch
    for (int m = 0; m < 4; m++) begin
      bus_in = 8'hF0 | 8'(m);
      conv_req(); repeat (MIN_W) tick();
      check_eq("R10", $sformatf("bipolar m=%0d", m), bip, m & 1);
      check_eq("R10", $sformatf("twos m=%0d", m), twos, (m >> 1) & 1);
      bus_in = ~bus_in;
      idle(); tick(); finish_conv(); tick();
      check_eq("R10", "bipolar held", bip, m & 1);
      check_eq("R10", "twos held", twos, (m >> 1) & 1);
    end

    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule